// File: doc/BRIEF.md
# Prescaled Timer Channel with Interrupt

This block is one timer channel of a sound and timer peripheral. It runs on the processor's machine-cycle clock. An 8-bit down-counter steps on a base tick that software selects: every cycle, a middle-rate tick once every 28 cycles, or a slow tick once every 114 cycles. When the counter steps while it is at zero, it reloads from the divisor register. If the channel's interrupt is enabled, this underflow latches an interrupt request.

The timing is exact to the cycle, so software can set the phase of its interrupts. A new divisor waits for the current count to run out. A change of base tick takes effect on the next cycle. Each prescaler restarts with a fixed latency when it leaves the hold state. Software clears the request by turning the enable bit off and on again.

Top module: `audtmr_chan`

## Requirements
- R1: After reset the request output is high (inactive), the divisor is 0, the interrupt is disabled, both prescalers are held and the full-rate tick is selected.
- R2: Register writes use address 0 for the divisor (data bits 7:0), address 1 for control (bits 1:0 select the tick: 00 every cycle, 01 middle rate, 10 or 11 slow rate; bits 5:4 are the prescaler run pair) and address 2 for interrupt enable (bit 0). A write takes effect at the clock edge where `bus_we` is high.
- R3: With the prescalers running, two consecutive underflows are (divisor+1)*P cycles apart, where P is 1, 28 or 114 for the selected tick.
- R4: A divisor write never changes the count in progress. The new value is loaded at the next underflow.
- R5: A write to the tick select takes effect on the cycle that follows the write edge.
- R6: While both run-pair bits are 0, the two prescalers are stopped and cleared, so the counter does not step in the middle or slow mode. The full-rate mode still counts. Either bit at 1 lets the prescalers run.
- R7: When the prescalers are released with the middle rate selected and the counter at 0, the first middle tick comes 21 cycles after the release edge. The counter sees that tick 2 cycles later, so the request goes low 23 cycles after the release edge. After that, ticks come every 28 cycles.
- R8: When the prescalers are released with the slow rate selected and the counter at 0, the request goes low 116 cycles after the release edge.
- R9: An underflow latches the request only while the enable bit is 1. With the divisor at 0 and full rate selected, enabling makes `irq_n` go low on the second edge after the enable write.
- R10: `irq_n` is active-low. Once low, it stays low until software writes the enable bit to 0, and it is high from the second edge after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| irq_n | output | 1 | Interrupt request, active low, level |

## Verification
The hardest case to reach is the prescaler phase just after a release. The counter only ever sees the prescaler through underflows, and a counter that is not at zero would hide where the first tick falls. The stimulus therefore starts from reset so the counter is at zero, holds the prescalers with the target tick selected and the interrupt enabled, and then releases them. The number of cycles from the release edge to the request gives the exact restart latency. Repeating the hold and release shows that the phase starts over each time.

// File: rtl/audtmr_chan.sv
module audtmr_chan #(
  parameter int DIV_W    = 8,
  parameter int MID_DIV  = 28,
  parameter int SLOW_DIV = 114,
  parameter int MID_LEAD = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic       irq_n
);
  localparam int MW = $clog2(MID_DIV);
  localparam int SW = $clog2(SLOW_DIV);

  logic [DIV_W-1:0] div_q, cnt_q;
  logic [1:0]       sel_q, pair_q;
  logic             en_q, stat_q;
  logic [MW-1:0]    mid_cnt;
  logic [SW-1:0]    slow_cnt;
  logic [1:0]       mid_pipe, slow_pipe;

  wire run       = |pair_q;
  wire mid_tick  = run && (mid_cnt == MW'(MID_DIV - 1));
  wire slow_tick = run && (slow_cnt == SW'(SLOW_DIV - 1));
  wire base_tick = (sel_q == 2'b00) ? 1'b1 :
                   (sel_q == 2'b01) ? mid_pipe[1] : slow_pipe[1];
  wire underflow = base_tick && (cnt_q == '0);

  assign irq_n = ~stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sel_q  <= 2'b00;
      pair_q <= 2'b00;
      en_q   <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        2'd0: div_q <= bus_wdata[DIV_W-1:0];
        2'd1: begin
          sel_q  <= bus_wdata[1:0];
          pair_q <= bus_wdata[5:4];
        end
        2'd2: en_q <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_cnt   <= MW'(MID_LEAD);
      slow_cnt  <= '0;
      mid_pipe  <= '0;
      slow_pipe <= '0;
    end else begin
      if (!run) begin
        mid_cnt  <= MW'(MID_LEAD);
        slow_cnt <= '0;
      end else begin
        mid_cnt  <= mid_tick  ? '0 : mid_cnt + 1'b1;
        slow_cnt <= slow_tick ? '0 : slow_cnt + 1'b1;
      end
      mid_pipe  <= {mid_pipe[0], mid_tick};
      slow_pipe <= {slow_pipe[0], slow_tick};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (base_tick) cnt_q <= underflow ? div_q : cnt_q - 1'b1;
      stat_q <= en_q && (stat_q || underflow);
    end
  end
endmodule

module audtmr_chan_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [1:0]       sel_q,
  input logic [1:0]       pair_q,
  input logic             en_q,
  input logic             base_tick,
  input logic [DIV_W-1:0] cnt_q,
  input logic             irq_n
);
  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> irq_n);

  assert_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && en_q) |=> !irq_n);

  assert_defer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0 && !base_tick) |=> $stable(cnt_q));

  assert_full_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'b00 && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != 2'b00 && pair_q == 2'b00 && $past(pair_q) == 2'b00 &&
     $past(pair_q, 2) == 2'b00 && $past(sel_q) == sel_q) |=> $stable(cnt_q));
endmodule

bind audtmr_chan audtmr_chan_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .sel_q(sel_q), .pair_q(pair_q), .en_q(en_q), .base_tick(base_tick),
  .cnt_q(cnt_q), .irq_n(irq_n)
);

// File: tb/audtmr_chan_tb.sv
module audtmr_chan_tb;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic irq_n;
  int n_chk = 0, n_bad = 0;

  audtmr_chan u_dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_n(irq_n));

  always #10 clk = ~clk;

  // {control, divisor, expected interval}
  localparam logic [31:0] VEC [9] = '{
    {8'h30, 8'd3,   16'd4},
    {8'h00, 8'd4,   16'd5},
    {8'h10, 8'd200, 16'd201},
    {8'h31, 8'd0,   16'd28},
    {8'h31, 8'd14,  16'd420},
    {8'h21, 8'd1,   16'd56},
    {8'h32, 8'd0,   16'd114},
    {8'h12, 8'd2,   16'd342},
    {8'h23, 8'd1,   16'd228}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 40000 && irq_n; i++) @(negedge clk);
  endtask

  task automatic measure(input int start, output int c);
    c = start;
    while (irq_n && c < 40000) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic clear_irq();
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h01);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c;
    bit hi;
    do_reset();
    chk(irq_n === 1'b1, "R1", irq_n, 1);
    hi = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_n !== 1'b1) hi = 1'b0;
    end
    chk(hi, "R9 disabled", hi, 1);
    wr(2'd2, 8'h01);
    chk(irq_n === 1'b1, "R9 enable edge", irq_n, 1);
    @(negedge clk);
    chk(irq_n === 1'b0, "R9 enable +1", irq_n, 0);
    repeat (5) @(negedge clk);
    chk(irq_n === 1'b0, "R10 latched", irq_n, 0);
    wr(2'd2, 8'h00);
    chk(irq_n === 1'b0, "R10 clear lag", irq_n, 0);
    @(negedge clk);
    chk(irq_n === 1'b1, "R10 cleared", irq_n, 1);

    // table: R2 R3 R6
    for (int v = 0; v < 9; v++) begin
      wr(2'd2, 8'h00);
      wr(2'd1, VEC[v][31:24]);
      wr(2'd0, VEC[v][23:16]);
      wr(2'd2, 8'h01);
      wait_irq();
      clear_irq();
      chk(irq_n === 1'b1, "R10 clear", irq_n, 1);
      measure(2, c);
      chk(c == int'(VEC[v][15:0]), $sformatf("R3 vector %0d", v), c, int'(VEC[v][15:0]));
    end

    // R4 deferred divisor
    do_reset();
    wr(2'd0, 8'd9);
    wr(2'd2, 8'h01);
    wait_irq();
    clear_irq();
    wr(2'd0, 8'd2);
    measure(3, c);
    chk(c == 10, "R4 count in progress", c, 10);
    clear_irq();
    measure(2, c);
    chk(c == 3, "R4 new divisor", c, 3);

    // R5 immediate switch
    do_reset();
    wr(2'd1, 8'h31);
    wr(2'd2, 8'h01);
    wait_irq();
    clear_irq();
    wr(2'd1, 8'h30);
    measure(3, c);
    chk(c == 4, "R5 switch to full rate", c, 4);

    // R6 hold, R7 middle restart
    do_reset();
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h01);
    hi = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irq_n !== 1'b1) hi = 1'b0;
    end
    chk(hi, "R6 held prescaler", hi, 1);
    wr(2'd1, 8'h31);
    measure(0, c);
    chk(c == 23, "R7 first middle tick", c, 23);
    clear_irq();
    measure(2, c);
    chk(c == 28, "R7 middle period", c, 28);
    wr(2'd1, 8'h01);
    clear_irq();
    repeat (40) @(negedge clk);
    chk(irq_n === 1'b1, "R6 hold again", irq_n, 1);
    wr(2'd1, 8'h31);
    measure(0, c);
    chk(c == 23, "R7 restart phase", c, 23);

    // R8 slow restart
    wr(2'd1, 8'h02);
    clear_irq();
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h32);
    measure(0, c);
    chk(c == 116, "R8 first slow tick", c, 116);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule